// File: doc/BRIEF.md
# Multicycle Shared-Resource CPU Datapath

This block is the 32-bit datapath of a small multicycle processor. Each instruction takes several clock cycles, and two units are shared across those cycles. One memory port handles both instruction fetch and data access. One ALU computes the PC increment, the branch target, effective addresses and the register-to-register results. Values that a later cycle needs are kept in holding registers that software cannot see: the instruction register, the memory data register, the two operand registers and the ALU result register. The block also contains the 32-entry register file and the program counter.

Every select and write enable comes from an external sequencer, which sees the instruction's opcode, its funct field and the ALU zero flag. Memory sits outside the block. The memory reads asynchronously on `mem_rdata`, and the sequencer performs stores using `mem_addr` and `mem_wdata`. The supported subset is add, sub, and, or, slt, load word, store word, branch-if-equal and jump. Instruction fields use the conventional 32-bit layout:

- opcode: bits 31:26
- rs: bits 25:21
- rt: bits 20:16
- rd: bits 15:11
- immediate: bits 15:0
- jump target: bits 25:0
- funct: bits 5:0

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is cleared to 0. The first fetch after reset therefore presents address 0 when `addr_sel` is 0.
- R2: When `addr_sel`=0, `mem_addr` equals the PC. With `ir_ld`=1, `opa_sel`=0, `opb_sel`=1, `alu_op`=ADD, `pc_src`=0 and `pc_wr_en`=1, the edge loads the instruction register from `mem_rdata` and sets the PC to PC+4. `opcode` shows IR[31:26] and `funct` shows IR[5:0].
- R3: The instruction register changes only at an edge where `ir_ld` is 1.
- R4: The `alu_op` codes are: 3'b000 AND, 3'b001 OR, 3'b010 ADD, 3'b110 SUB, 3'b111 signed set-less-than (result 1 or 0). `alu_zero` is 1 exactly when the ALU result is 0.
- R5: The first operand is the PC when `opa_sel`=0 and register A when `opa_sel`=1. The second operand depends on `opb_sel`: 0 selects register B, 1 selects the constant 4, 2 selects the sign-extended immediate, and 3 selects the sign-extended immediate shifted left by 2.
- R6: With `dst_sel`=1, `wb_sel`=0 and `rf_wr`=1, the ALU result register is written to the register numbered IR[15:11].
- R7: When `addr_sel`=1, `mem_addr` is the ALU result register. The memory data register captures `mem_rdata` on every edge. With `dst_sel`=0, `wb_sel`=1 and `rf_wr`=1, the memory data register is written to the register numbered IR[20:16].
- R8: `mem_wdata` is operand register B. B holds the register named by IR[20:16], read on the previous edge.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: When `pc_wr_cond` is 1 and `pc_wr_en` is 0, the PC loads the next-PC value only if `alu_zero` is 1; otherwise the PC holds. `pc_src`=1 selects the ALU result register as the next PC.
- R11: `pc_src`=2 selects the jump address, formed as {PC[31:28], IR[25:0], 2'b00}. `pc_src`=0 selects the live ALU output.
- R12: When both `pc_wr_en` and `pc_wr_cond` are 0, the PC does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr_en | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write qualified by the zero flag |
| addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result register |
| ir_ld | input | 1 | Instruction register load enable |
| dst_sel | input | 1 | Write register number: 0 IR[20:16], 1 IR[15:11] |
| wb_sel | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| rf_wr | input | 1 | Register file write enable |
| opa_sel | input | 1 | ALU first operand select |
| opb_sel | input | 2 | ALU second operand select |
| pc_src | input | 2 | Next-PC select |
| alu_op | input | 3 | ALU operation code |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (operand B) |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| alu_zero | output | 1 | ALU result equals zero |

## Verification
The bench acts as the sequencer and keeps a model of the register file, so every computed value is observed later through a store's write data.

- **Instruction register hold.** The word at the incremented PC is deliberately different from the fetched instruction. A design that reloads the instruction register outside `ir_ld` shows the wrong opcode after decode.
- **Register zero.** Writes to register 0, both from the ALU and from a load, are stored back out. A design without zero protection leaks the written value.
- **Sign extension.** A load uses a negative offset. Wrong sign extension puts the wrong address on the memory port.
- **Branches.** Branches are tested taken, not taken, and backward past address 0. The backward branch leaves a PC whose top bits are all ones, and the jump that follows must carry those four bits into its target. A design that ignores the zero flag, or builds the jump from the wrong PC bits, fetches from an unexpected address.
- **Signed compare.** Set-less-than is tried with a negative operand in each position, which separates a signed compare from an unsigned one.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int DW      = 32;
    localparam int REG_CNT = 32;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] mdr;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [DW-1:0] alu_out;
    } dp_state_t;

endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] result,
    output logic         is_zero
);

    logic [W-1:0] diff;

    always_comb begin
        diff = in_a - in_b;
        unique case (op)
            ALU_AND: result = in_a & in_b;
            ALU_OR:  result = in_a | in_b;
            ALU_ADD: result = in_a + in_b;
            ALU_SUB: result = diff;
            ALU_SLT: result = {{(W-1){1'b0}}, ($signed(in_a) < $signed(in_b))};
            default: result = in_a + in_b;
        endcase
        is_zero = (result == '0);
    end

endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
        (regs_q[0] == '0)); // R9

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_wr_en,
    input  logic        pc_wr_cond,
    input  logic        addr_sel,
    input  logic        ir_ld,
    input  logic        dst_sel,
    input  logic        wb_sel,
    input  logic        rf_wr,
    input  logic        opa_sel,
    input  logic [1:0]  opb_sel,
    input  logic [1:0]  pc_src,
    input  logic [2:0]  alu_op,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [5:0]  opcode,
    output logic [5:0]  funct,
    output logic        alu_zero
);

    localparam int W     = DW;
    localparam int RAW   = $clog2(REG_CNT);
    localparam int IMM_W = 16;

    dp_state_t st_q, st_d;

    logic [W-1:0]   rf_a, rf_b, wb_data;
    logic [RAW-1:0] wb_addr;
    logic [W-1:0]   imm_sx, op_a, op_b, alu_y, jump_tgt, pc_next;
    logic           pc_load;

    mcd_regfile #(.W(W), .N(REG_CNT), .AW(RAW)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_wr),
        .waddr   (wb_addr),
        .wdata   (wb_data),
        .raddr_a (st_q.ir[25:21]),
        .raddr_b (st_q.ir[20:16]),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    mcd_alu #(.W(W)) i_alu (
        .op      (alu_op),
        .in_a    (op_a),
        .in_b    (op_b),
        .result  (alu_y),
        .is_zero (alu_zero)
    );

    always_comb begin
        imm_sx   = {{(W-IMM_W){st_q.ir[IMM_W-1]}}, st_q.ir[IMM_W-1:0]};
        op_a     = opa_sel ? st_q.opa : st_q.pc;
        unique case (opb_sel)
            2'd0:    op_b = st_q.opb;
            2'd1:    op_b = W'(4);
            2'd2:    op_b = imm_sx;
            default: op_b = {imm_sx[W-3:0], 2'b00};
        endcase
        jump_tgt = {st_q.pc[W-1:W-4], st_q.ir[25:0], 2'b00};
        unique case (pc_src)
            2'd1:    pc_next = st_q.alu_out;
            2'd2:    pc_next = jump_tgt;
            default: pc_next = alu_y;
        endcase
        pc_load  = pc_wr_en | (pc_wr_cond & alu_zero);
        wb_addr  = dst_sel ? st_q.ir[15:11] : st_q.ir[20:16];
        wb_data  = wb_sel ? st_q.mdr : st_q.alu_out;

        st_d         = st_q;
        st_d.pc      = pc_load ? pc_next : st_q.pc;
        st_d.ir      = ir_ld ? mem_rdata : st_q.ir;
        st_d.mdr     = mem_rdata;
        st_d.opa     = rf_a;
        st_d.opb     = rf_b;
        st_d.alu_out = alu_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = addr_sel ? st_q.alu_out : st_q.pc;
    assign mem_wdata = st_q.opb;
    assign opcode    = st_q.ir[31:26];
    assign funct     = st_q.ir[5:0];

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (st_q.pc == '0)); // R1
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_ld |=> $stable(st_q.ir)); // R3
    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (rst)
        (alu_op == ALU_SLT) |-> (alu_y[W-1:1] == '0)); // R4
    AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && !pc_wr_en && !alu_zero) |=> $stable(st_q.pc)); // R10
    AST_JUMP_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_en && pc_src == 2'd2) |=> (st_q.pc[1:0] == 2'b00)); // R11
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr_en && !pc_wr_cond) |=> $stable(st_q.pc)); // R12

endmodule

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;

    logic        clk = 1'b0;
    logic        rst;
    logic        pc_wr_en, pc_wr_cond, addr_sel, ir_ld, dst_sel, wb_sel, rf_wr, opa_sel;
    logic [1:0]  opb_sel, pc_src;
    logic [2:0]  alu_op;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic [5:0]  opcode, funct;
    logic        alu_zero;

    logic [31:0] mem [256];
    logic [31:0] exp_pc;
    int          n_chk  = 0;
    int          n_fail = 0;

    localparam logic [2:0] A_AND = 3'b000, A_OR = 3'b001, A_ADD = 3'b010,
                           A_SUB = 3'b110, A_SLT = 3'b111;

    // funct, alu_op, rs, rt, rd, expected (r1 = 7, r2 = -3)
    typedef struct packed {
        logic [5:0]  fn;
        logic [2:0]  aop;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [31:0] res;
    } rvec_t;

    localparam rvec_t RTAB [6] = '{
        '{6'h20, 3'b010, 5'd1, 5'd2, 5'd3, 32'h0000_0004},
        '{6'h22, 3'b110, 5'd1, 5'd2, 5'd4, 32'h0000_000A},
        '{6'h24, 3'b000, 5'd1, 5'd2, 5'd5, 32'h0000_0005},
        '{6'h25, 3'b001, 5'd1, 5'd2, 5'd6, 32'hFFFF_FFFF},
        '{6'h2A, 3'b111, 5'd1, 5'd2, 5'd7, 32'h0000_0000},
        '{6'h2A, 3'b111, 5'd2, 5'd1, 5'd8, 32'h0000_0001}
    };

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    mc_datapath i_mc_datapath (
        .clk(clk), .rst(rst), .pc_wr_en(pc_wr_en), .pc_wr_cond(pc_wr_cond),
        .addr_sel(addr_sel), .ir_ld(ir_ld), .dst_sel(dst_sel), .wb_sel(wb_sel),
        .rf_wr(rf_wr), .opa_sel(opa_sel), .opb_sel(opb_sel), .pc_src(pc_src),
        .alu_op(alu_op), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic set_ctl(input logic pcw, input logic pcc, input logic asel, input logic irl,
                           input logic dsel, input logic wsel, input logic rfw, input logic oas,
                           input logic [1:0] obs, input logic [1:0] psrc, input logic [2:0] aop);
        pc_wr_en = pcw; pc_wr_cond = pcc; addr_sel = asel; ir_ld = irl;
        dst_sel = dsel; wb_sel = wsel; rf_wr = rfw; opa_sel = oas;
        opb_sel = obs; pc_src = psrc; alu_op = aop;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Fetch and decode cycles
    task automatic do_fetch(input logic [31:0] instr);
        mem[exp_pc[9:2]] = instr;
        set_ctl(1, 0, 0, 1, 0, 0, 0, 0, 2'd1, 2'd0, A_ADD);
        #1 check("R2 fetch address", mem_addr, exp_pc);
        tick();
        check("R2 opcode", {26'd0, opcode}, {26'd0, instr[31:26]});
        exp_pc = exp_pc + 4;
        set_ctl(0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 2'd0, A_ADD);
        tick();
        #1 check("R12 PC held in decode", mem_addr, exp_pc);
    endtask

    task automatic do_load(input logic [4:0] rt, input logic [4:0] base, input logic [15:0] imm,
                           input logic [31:0] exp_addr);
        do_fetch({6'h23, base, rt, imm});
        check("R3 IR held after decode", {26'd0, opcode}, 32'h23);
        set_ctl(0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 2'd0, A_ADD);
        tick();
        set_ctl(0, 0, 1, 0, 0, 0, 0, 0, 2'd0, 2'd0, A_ADD);
        #1 check("R5 R7 load address", mem_addr, exp_addr);
        tick();
        set_ctl(0, 0, 0, 0, 0, 1, 1, 0, 2'd0, 2'd0, A_ADD);
        tick();
    endtask

    task automatic do_store(input logic [4:0] rt, input logic [4:0] base, input logic [15:0] imm,
                            input logic [31:0] exp_data, input string req);
        do_fetch({6'h2B, base, rt, imm});
        set_ctl(0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 2'd0, A_ADD);
        tick();
        set_ctl(0, 0, 1, 0, 0, 0, 0, 0, 2'd0, 2'd0, A_ADD);
        #1 check({req, " R8 store data"}, mem_wdata, exp_data);
        mem[mem_addr[9:2]] = mem_wdata;
        tick();
    endtask

    task automatic do_rtype(input rvec_t v);
        do_fetch({6'h00, v.rs, v.rt, v.rd, 5'd0, v.fn});
        check("R2 funct", {26'd0, funct}, {26'd0, v.fn});
        set_ctl(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 2'd0, v.aop);
        tick();
        set_ctl(0, 0, 0, 0, 1, 0, 1, 0, 2'd0, 2'd0, A_ADD);
        tick();
    endtask

    task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm,
                          input logic taken);
        do_fetch({6'h04, rs, rt, imm});
        set_ctl(0, 1, 0, 0, 0, 0, 0, 1, 2'd0, 2'd1, A_SUB);
        #1 check("R4 R10 zero flag", {31'd0, alu_zero}, {31'd0, taken});
        tick();
        if (taken) exp_pc = exp_pc + {{14{imm[15]}}, imm, 2'b00};
    endtask

    task automatic do_jump(input logic [25:0] tgt);
        do_fetch({6'h02, tgt});
        set_ctl(1, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd2, A_ADD);
        tick();
        exp_pc = {exp_pc[31:28], tgt, 2'b00};
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] back_off;
        for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
        mem[128] = 32'h0000_0007;
        mem[129] = 32'hFFFF_FFFD;
        mem[130] = 32'h0000_0208;
        set_ctl(0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 2'd0, A_ADD);
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        #1 check("R1 PC after reset", mem_addr, 32'h0);
        exp_pc = 32'h0;

        do_load(5'd1, 5'd0, 16'h0200, 32'h200);
        do_load(5'd2, 5'd0, 16'h0204, 32'h204);
        do_store(5'd1, 5'd0, 16'h0300, 32'h7, "R7 load r1");
        do_store(5'd2, 5'd0, 16'h0300, 32'hFFFF_FFFD, "R7 load r2");

        for (int k = 0; k < 6; k++) begin
            do_rtype(RTAB[k]);
            do_store(RTAB[k].rd, 5'd0, 16'h0304 + 16'(4 * k), RTAB[k].res, "R4 R6 rtype");
        end
        check("R8 stored word in memory", mem[193], 32'h4);

        // register 0 protection, from ALU and from load
        do_rtype('{6'h20, A_ADD, 5'd1, 5'd1, 5'd0, 32'h0});
        do_store(5'd0, 5'd0, 16'h0320, 32'h0, "R9 alu write r0");
        do_load(5'd0, 5'd0, 16'h0200, 32'h200);
        do_store(5'd0, 5'd0, 16'h0320, 32'h0, "R9 load write r0");

        // negative offset: r11 = 0x208, load from r11-8
        do_load(5'd11, 5'd0, 16'h0208, 32'h208);
        do_load(5'd12, 5'd11, 16'hFFF8, 32'h200);
        do_store(5'd12, 5'd0, 16'h0324, 32'h7, "R5 negative offset");

        // branches
        do_beq(5'd1, 5'd2, 16'h0004, 1'b0);
        do_load(5'd9, 5'd3, 16'h01FC, 32'h200);
        do_beq(5'd1, 5'd9, 16'h0002, 1'b1);
        do_store(5'd9, 5'd0, 16'h0328, 32'h7, "R10 taken branch");
        back_off = 16'((32'hFFFF_FFF0 - (exp_pc + 4)) >> 2);
        do_beq(5'd0, 5'd0, back_off, 1'b1);
        check("R10 backward target", exp_pc, 32'hFFFF_FFF0);
        do_jump(26'h40);
        check("R11 jump target", exp_pc, 32'hF000_0100);
        do_store(5'd4, 5'd0, 16'h032C, 32'hA, "R11 after jump");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule